// File: doc/BRIEF.md
# Two-Master Shared RAM with Byte Parity

This block is a small synchronous single-port RAM reached by two masters: a main CPU and a coprocessor. A configuration register decides who may touch the memory. It can belong to the CPU alone, be shared for data between both masters, or be handed to the coprocessor as instruction memory. In that last case the CPU keeps only debug reach. Each request carries an access kind: data read, data write, instruction fetch, debug read or debug write. The block checks the kind against the current ownership mode and two CPU protection bits. A refused access leaves the memory untouched, returns zero, and raises a violation pulse on the port of the master that made it.

Every byte is stored with an even-parity bit, computed on write and checked on every permitted read. An error-injection input stores inverted parity, so the checking path can be exercised. Only one access is served per cycle. The CPU has fixed priority, and the coprocessor is held off through its ready signal when both masters request in the same cycle.

Top module: `dual_master_ram`

## Requirements
- R1: After reset the RAM is owned by the CPU alone. All outputs are zero except cop_ready, and any coprocessor access is refused.
- R2: With ownership code 00, and with the reserved codes 10 and 11, the program flag has no effect. The CPU may use every kind and the coprocessor may use none.
- R3: With ownership code 01 and program flag 0, the CPU may use every kind. The coprocessor may do data reads (kind 0) and data writes (kind 1), and its fetches and debug accesses are refused.
- R4: With ownership code 01 and program flag 1, the coprocessor may only fetch (kind 2). The CPU may only do debug reads (kind 3) and debug writes (kind 4).
- R5: A refused access, including one with an undefined kind code 5 to 7, writes nothing. On the cycle after the request it returns zero data and raises a one-cycle violation on the requesting master's port.
- R6: The write-protect bit refuses CPU data writes and the fetch-protect bit refuses CPU fetches, in every mode. CPU debug writes and all coprocessor accesses are not affected by these bits.
- R7: Read-type requests (kinds 0, 2, 3) raise rvalid on the cycle after the request. When the access is permitted, the stored word arrives on the same cycle.
- R8: When both masters request in the same cycle, cop_ready is low in that cycle, the CPU access is served, and the coprocessor access is dropped with no write, rvalid or violation.
- R9: Writes change only the bytes whose byte-enable bit is set (bit i selects bits 8i+7..8i).
- R10: Each byte keeps an even-parity bit. A permitted read of a word with any bad byte raises par_err for one cycle, together with rvalid, with the word address on par_err_addr. A write made while inj_par_err is high stores inverted parity for the enabled bytes.
- R11: A configuration load takes effect for accesses from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the configuration register |
| cfg_msel | input | 2 | Ownership code (00 CPU only, 01 shared, 10/11 as 00) |
| cfg_prog | input | 1 | Coprocessor program-memory flag |
| cfg_wprot | input | 1 | Refuse CPU data writes |
| cfg_fprot | input | 1 | Refuse CPU fetches |
| inj_par_err | input | 1 | Store inverted parity on the current write |
| cpu_req | input | 1 | CPU request |
| cpu_kind | input | 3 | CPU access kind (0 rd, 1 wr, 2 fetch, 3 dbg rd, 4 dbg wr) |
| cpu_addr | input | AW | CPU word address |
| cpu_wdata | input | 8*NB | CPU write data |
| cpu_be | input | NB | CPU byte enables |
| cpu_rvalid | output | 1 | CPU read response |
| cpu_rdata | output | 8*NB | CPU read data |
| cpu_viol | output | 1 | CPU access refused |
| cop_req | input | 1 | Coprocessor request |
| cop_kind | input | 3 | Coprocessor access kind |
| cop_addr | input | AW | Coprocessor word address |
| cop_wdata | input | 8*NB | Coprocessor write data |
| cop_be | input | NB | Coprocessor byte enables |
| cop_ready | output | 1 | Low when the coprocessor is stalled by the CPU |
| cop_rvalid | output | 1 | Coprocessor read response |
| cop_rdata | output | 8*NB | Coprocessor read data |
| cop_viol | output | 1 | Coprocessor access refused |
| par_err | output | 1 | Parity mismatch on the read being returned |
| par_err_addr | output | AW | Address of the failing word |

## Verification
The assertions watch, on every cycle, the rules that can be seen from a single request: the coprocessor is refused outside the shared mode, CPU data reads are refused in program mode, write protection refuses CPU writes, refused reads return zero, the read response comes one cycle after the request, a collision stalls the coprocessor, and a parity error appears only with a read response. Memory content cannot be seen from one cycle. Only the bench scenarios can show that refused or dropped writes really leave data intact, that byte enables merge correctly, that injected parity is caught and later cleared by a clean rewrite, and that a configuration load acts from the very next access.

// File: rtl/dmr_pkg.sv
package dmr_pkg;

  typedef enum logic [2:0] {
    K_RD    = 3'd0,
    K_WR    = 3'd1,
    K_FETCH = 3'd2,
    K_DBGRD = 3'd3,
    K_DBGWR = 3'd4
  } kind_e;

  localparam logic [1:0] OWN_SHARED = 2'b01;

  typedef struct packed {
    logic [1:0] msel;
    logic       prog;
    logic       wprot;
    logic       fprot;
  } cfg_t;

  function automatic logic kind_reads(input logic [2:0] k);
    return (k == K_RD) || (k == K_FETCH) || (k == K_DBGRD);
  endfunction

  function automatic logic kind_writes(input logic [2:0] k);
    return (k == K_WR) || (k == K_DBGWR);
  endfunction

endpackage

// File: rtl/dmr_cfg.sv
module dmr_cfg
  import dmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [1:0] msel,
  input  logic       prog,
  input  logic       wprot,
  input  logic       fprot,
  output cfg_t       cfg
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg <= '0;
    end else if (we) begin
      cfg.msel  <= msel;
      cfg.prog  <= prog;
      cfg.wprot <= wprot;
      cfg.fprot <= fprot;
    end
  end

endmodule

// File: rtl/dmr_perm.sv
module dmr_perm
  import dmr_pkg::*;
#(
  parameter bit IS_CPU = 1'b1
) (
  input  cfg_t       cfg,
  input  logic [2:0] kind,
  output logic       ok
);

  logic shared_mode;
  logic prog_mode;

  assign shared_mode = (cfg.msel == OWN_SHARED);
  assign prog_mode   = shared_mode && cfg.prog;

  generate
    if (IS_CPU) begin : g_cpu
      always_comb begin
        if (prog_mode) begin
          ok = (kind == K_DBGRD) || (kind == K_DBGWR);
        end else begin
          ok = (kind <= K_DBGWR)
               && !((kind == K_WR) && cfg.wprot)
               && !((kind == K_FETCH) && cfg.fprot);
        end
      end
    end else begin : g_cop
      always_comb begin
        if (!shared_mode) begin
          ok = 1'b0;
        end else if (cfg.prog) begin
          ok = (kind == K_FETCH);
        end else begin
          ok = (kind == K_RD) || (kind == K_WR);
        end
      end
    end
  endgenerate

endmodule

// File: rtl/dmr_bank.sv
module dmr_bank #(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic [NB-1:0]   we,
  input  logic [AW-1:0]   addr,
  input  logic [8*NB-1:0] wdata,
  input  logic            inj,
  output logic [8*NB-1:0] rdata,
  output logic [NB-1:0]   rpar
);

  localparam int DEPTH = 1 << AW;

  generate
    for (genvar g = 0; g < NB; g++) begin : g_lane
      logic [8:0] mem [DEPTH];
      logic [8:0] q;
      logic [7:0] byte_in;

      assign byte_in = wdata[8*g +: 8];

      always_ff @(posedge clk) begin
        if (we[g]) begin
          mem[addr] <= {(^byte_in) ^ inj, byte_in};
        end
        q <= mem[addr];
      end

      assign rdata[8*g +: 8] = q[7:0];
      assign rpar[g]         = q[8];
    end
  endgenerate

endmodule

// File: rtl/dual_master_ram.sv
module dual_master_ram
  import dmr_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cfg_we,
  input  logic [1:0]      cfg_msel,
  input  logic            cfg_prog,
  input  logic            cfg_wprot,
  input  logic            cfg_fprot,
  input  logic            inj_par_err,
  input  logic            cpu_req,
  input  logic [2:0]      cpu_kind,
  input  logic [AW-1:0]   cpu_addr,
  input  logic [8*NB-1:0] cpu_wdata,
  input  logic [NB-1:0]   cpu_be,
  output logic            cpu_rvalid,
  output logic [8*NB-1:0] cpu_rdata,
  output logic            cpu_viol,
  input  logic            cop_req,
  input  logic [2:0]      cop_kind,
  input  logic [AW-1:0]   cop_addr,
  input  logic [8*NB-1:0] cop_wdata,
  input  logic [NB-1:0]   cop_be,
  output logic            cop_ready,
  output logic            cop_rvalid,
  output logic [8*NB-1:0] cop_rdata,
  output logic            cop_viol,
  output logic            par_err,
  output logic [AW-1:0]   par_err_addr
);

  localparam int DW = 8 * NB;

  cfg_t cfg_q;

  dmr_cfg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .we    (cfg_we),
    .msel  (cfg_msel),
    .prog  (cfg_prog),
    .wprot (cfg_wprot),
    .fprot (cfg_fprot),
    .cfg   (cfg_q)
  );

  logic cpu_ok;
  logic cop_ok;

  dmr_perm #(.IS_CPU(1'b1)) u_perm_cpu (
    .cfg  (cfg_q),
    .kind (cpu_kind),
    .ok   (cpu_ok)
  );

  dmr_perm #(.IS_CPU(1'b0)) u_perm_cop (
    .cfg  (cfg_q),
    .kind (cop_kind),
    .ok   (cop_ok)
  );

  // Fixed priority: the CPU is served whenever it asks.
  logic cop_go;
  assign cop_go    = cop_req && !cpu_req;
  assign cop_ready = !(cpu_req && cop_req);

  logic [2:0]    s_kind;
  logic [AW-1:0] s_addr;
  logic [DW-1:0] s_wdata;
  logic [NB-1:0] s_be;
  logic          s_ok;
  logic          s_any;

  always_comb begin
    if (cpu_req) begin
      s_kind  = cpu_kind;
      s_addr  = cpu_addr;
      s_wdata = cpu_wdata;
      s_be    = cpu_be;
      s_ok    = cpu_ok;
    end else begin
      s_kind  = cop_kind;
      s_addr  = cop_addr;
      s_wdata = cop_wdata;
      s_be    = cop_be;
      s_ok    = cop_ok;
    end
  end

  assign s_any = cpu_req || cop_go;

  logic [NB-1:0] mem_we;
  assign mem_we = {NB{s_any && s_ok && kind_writes(s_kind)}} & s_be;

  logic [DW-1:0] bank_rdata;
  logic [NB-1:0] bank_rpar;

  dmr_bank #(.AW(AW), .NB(NB)) u_bank (
    .clk   (clk),
    .we    (mem_we),
    .addr  (s_addr),
    .wdata (s_wdata),
    .inj   (inj_par_err),
    .rdata (bank_rdata),
    .rpar  (bank_rpar)
  );

  // Response pipeline, aligned with the one-cycle bank read.
  logic          cpu_good_q;
  logic          cop_good_q;
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rvalid <= 1'b0;
      cpu_viol   <= 1'b0;
      cpu_good_q <= 1'b0;
      cop_rvalid <= 1'b0;
      cop_viol   <= 1'b0;
      cop_good_q <= 1'b0;
      addr_q     <= '0;
    end else begin
      cpu_rvalid <= cpu_req && kind_reads(cpu_kind);
      cpu_viol   <= cpu_req && !cpu_ok;
      cpu_good_q <= cpu_req && cpu_ok && kind_reads(cpu_kind);
      cop_rvalid <= cop_go && kind_reads(cop_kind);
      cop_viol   <= cop_go && !cop_ok;
      cop_good_q <= cop_go && cop_ok && kind_reads(cop_kind);
      addr_q     <= s_addr;
    end
  end

  logic [NB-1:0] lane_bad;

  generate
    for (genvar g = 0; g < NB; g++) begin : g_chk
      assign lane_bad[g] = ^{bank_rpar[g], bank_rdata[8*g +: 8]};
    end
  endgenerate

  logic rd_live;
  assign rd_live = cpu_good_q || cop_good_q;

  assign cpu_rdata    = cpu_good_q ? bank_rdata : '0;
  assign cop_rdata    = cop_good_q ? bank_rdata : '0;
  assign par_err      = rd_live && (|lane_bad);
  assign par_err_addr = par_err ? addr_q : '0;

endmodule

// File: rtl/dmr_chk.sv
module dmr_chk
  import dmr_pkg::*;
#(
  parameter int AW = 8,
  parameter int NB = 4
) (
  input logic            clk,
  input logic            rst,
  input cfg_t            cfg_q,
  input logic            cpu_req,
  input logic [2:0]      cpu_kind,
  input logic            cpu_rvalid,
  input logic [8*NB-1:0] cpu_rdata,
  input logic            cpu_viol,
  input logic            cop_req,
  input logic            cop_ready,
  input logic            cop_rvalid,
  input logic [8*NB-1:0] cop_rdata,
  input logic            cop_viol,
  input logic            par_err
);

  // R1, R2: outside the shared code the coprocessor is always refused
  a_r2_cop_refused: assert property (@(posedge clk) disable iff (rst)
    (cop_req && !cpu_req && cfg_q.msel != OWN_SHARED) |=> (cop_viol && cop_rdata == '0));

  // R4: program mode refuses CPU data reads
  a_r4_cpu_data_blocked: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_kind == K_RD && cfg_q.msel == OWN_SHARED && cfg_q.prog)
    |=> (cpu_viol && cpu_rdata == '0));

  // R5: a refused access never returns data
  a_r5_viol_zero: assert property (@(posedge clk) disable iff (rst)
    (cpu_viol |-> cpu_rdata == '0) and (cop_viol |-> cop_rdata == '0));

  // R6: write protection refuses CPU data writes
  a_r6_wprot: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_kind == K_WR && cfg_q.wprot) |=> cpu_viol);

  // R7: read response one cycle after the request
  a_r7_latency: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cpu_kind == K_RD) |=> cpu_rvalid);

  // R8: a collision stalls and drops the coprocessor access
  a_r8_stall: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cop_req) |-> !cop_ready);

  a_r8_dropped: assert property (@(posedge clk) disable iff (rst)
    (cpu_req && cop_req) |=> (!cop_rvalid && !cop_viol));

  // R10: a parity error only accompanies a read response
  a_r10_perr_with_read: assert property (@(posedge clk) disable iff (rst)
    par_err |-> (cpu_rvalid || cop_rvalid));

endmodule

bind dual_master_ram dmr_chk #(.AW(AW), .NB(NB)) u_chk (.*);

// File: tb/tb_dual_master_ram.sv
module tb_dual_master_ram;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int NB = 4;
  localparam int DW = 8 * NB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_we = 0, cfg_prog = 0, cfg_wprot = 0, cfg_fprot = 0, inj_par_err = 0;
  logic [1:0] cfg_msel = 0;
  logic cpu_req = 0, cop_req = 0;
  logic [2:0] cpu_kind = 0, cop_kind = 0;
  logic [AW-1:0] cpu_addr = 0, cop_addr = 0;
  logic [DW-1:0] cpu_wdata = 0, cop_wdata = 0;
  logic [NB-1:0] cpu_be = 0, cop_be = 0;
  logic cpu_rvalid, cpu_viol, cop_ready, cop_rvalid, cop_viol, par_err;
  logic [DW-1:0] cpu_rdata, cop_rdata;
  logic [AW-1:0] par_err_addr;

  dual_master_ram #(.AW(AW), .NB(NB)) dut (.*);

  always #(CLK_PERIOD / 2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct {
    int          due;
    bit          rv;
    logic [31:0] d;
    bit          viol;
    bit          perr;
    logic [7:0]  pa;
    string       tag;
  } exp_t;

  exp_t qc[$];
  exp_t qp[$];
  int n_chk = 0;
  int n_bad = 0;

  // Reference state built from the requirements
  logic [31:0] mdl [256];
  logic [3:0]  bad [256];
  logic [1:0]  m_msel = 0;
  bit m_prog = 0, m_wp = 0, m_fp = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  function automatic bit allow(input bit is_cpu, input logic [2:0] k);
    bit sh = (m_msel == 2'b01);
    if (is_cpu) begin
      if (sh && m_prog) return (k == 3) || (k == 4);
      return (k <= 4) && !(k == 1 && m_wp) && !(k == 2 && m_fp);
    end
    if (!sh) return 0;
    if (m_prog) return k == 2;
    return (k == 0) || (k == 1);
  endfunction

  // Monitor: pops expectations as the responses come out
  exp_t e;
  always @(negedge clk) begin
    while (qc.size() > 0 && qc[0].due == cyc) begin
      e = qc.pop_front();
      chk(cpu_rvalid == e.rv, e.tag, "cpu_rvalid", 64'(cpu_rvalid), 64'(e.rv));
      chk(cpu_rdata == e.d, e.tag, "cpu_rdata", 64'(cpu_rdata), 64'(e.d));
      chk(cpu_viol == e.viol, e.tag, "cpu_viol", 64'(cpu_viol), 64'(e.viol));
      chk(par_err == e.perr, e.tag, "par_err", 64'(par_err), 64'(e.perr));
      if (e.perr)
        chk(par_err_addr == e.pa, e.tag, "par_err_addr", 64'(par_err_addr), 64'(e.pa));
    end
    while (qp.size() > 0 && qp[0].due == cyc) begin
      e = qp.pop_front();
      chk(cop_rvalid == e.rv, e.tag, "cop_rvalid", 64'(cop_rvalid), 64'(e.rv));
      chk(cop_rdata == e.d, e.tag, "cop_rdata", 64'(cop_rdata), 64'(e.d));
      chk(cop_viol == e.viol, e.tag, "cop_viol", 64'(cop_viol), 64'(e.viol));
    end
  end

  // Driver: one cycle, both masters, expectations pushed to the scoreboard
  task automatic step(input bit c_on, input logic [2:0] ck, input logic [7:0] ca,
                      input logic [31:0] cw, input logic [3:0] cb,
                      input bit p_on, input logic [2:0] pk, input logic [7:0] pa,
                      input logic [31:0] pw, input logic [3:0] pb,
                      input bit inj, input string tag);
    exp_t ec;
    exp_t ep;
    bit served_cpu;
    bit ok;
    bit rd;
    logic [2:0] k;
    logic [7:0] a;
    logic [31:0] w;
    logic [3:0] b;
    @(negedge clk);
    cfg_we = 0;
    cpu_req = c_on; cpu_kind = ck; cpu_addr = ca; cpu_wdata = cw; cpu_be = cb;
    cop_req = p_on; cop_kind = pk; cop_addr = pa; cop_wdata = pw; cop_be = pb;
    inj_par_err = inj;
    ec = '{due: cyc + 1, rv: 0, d: 0, viol: 0, perr: 0, pa: 0, tag: tag};
    ep = ec;
    served_cpu = c_on;
    if (c_on || p_on) begin
      k = c_on ? ck : pk;
      a = c_on ? ca : pa;
      w = c_on ? cw : pw;
      b = c_on ? cb : pb;
      ok = allow(served_cpu, k);
      rd = (k == 0) || (k == 2) || (k == 3);
      if (served_cpu) begin
        ec.rv = rd; ec.viol = !ok;
        if (ok && rd) ec.d = mdl[a];
      end else begin
        ep.rv = rd; ep.viol = !ok;
        if (ok && rd) ep.d = mdl[a];
      end
      if (ok && rd && (bad[a] != 0)) begin
        ec.perr = 1; ec.pa = a;
      end
      if (ok && (k == 1 || k == 4)) begin
        for (int i = 0; i < NB; i++) begin
          if (b[i]) begin
            mdl[a][8*i +: 8] = w[8*i +: 8];
            bad[a][i] = inj;
          end
        end
      end
    end
    qc.push_back(ec);
    qp.push_back(ep);
    #1;
    chk(cop_ready == !(c_on && p_on), "R8", "cop_ready", 64'(cop_ready), 64'(!(c_on && p_on)));
  endtask

  task automatic cpu_op(input logic [2:0] k, input logic [7:0] a, input logic [31:0] w,
                        input logic [3:0] b, input string tag);
    step(1, k, a, w, b, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic cop_op(input logic [2:0] k, input logic [7:0] a, input logic [31:0] w,
                        input logic [3:0] b, input string tag);
    step(0, 0, 0, 0, 0, 1, k, a, w, b, 0, tag);
  endtask

  task automatic set_cfg(input logic [1:0] ms, input bit pr, input bit wp, input bit fp);
    @(negedge clk);
    cpu_req = 0; cop_req = 0; inj_par_err = 0;
    cfg_we = 1; cfg_msel = ms; cfg_prog = pr; cfg_wprot = wp; cfg_fprot = fp;
    qc.push_back('{due: cyc + 1, rv: 0, d: 0, viol: 0, perr: 0, pa: 0, tag: "R11 cfg cycle"});
    qp.push_back('{due: cyc + 1, rv: 0, d: 0, viol: 0, perr: 0, pa: 0, tag: "R11 cfg cycle"});
    m_msel = ms; m_prog = pr; m_wp = wp; m_fp = fp;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin
      mdl[i] = 0;
      bad[i] = 0;
    end
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset state at the ports
    chk(cpu_rvalid == 0 && cpu_viol == 0 && cpu_rdata == 0, "R1", "cpu outputs", 64'(cpu_rvalid), 0);
    chk(cop_rvalid == 0 && cop_viol == 0 && cop_rdata == 0, "R1", "cop outputs", 64'(cop_rvalid), 0);
    chk(par_err == 0 && cop_ready == 1, "R1", "par_err/ready", 64'({par_err, cop_ready}), 64'(1));

    for (int a = 0; a < 16; a++) cpu_op(1, 8'(a), 32'h0, 4'hf, "R2 clear");
    cpu_op(1, 5, 32'h11223344, 4'hf, "R2 cpu write");
    cpu_op(0, 5, 0, 0, "R7 cpu read");
    cop_op(0, 5, 0, 0, "R1 cop read after reset");
    cop_op(1, 5, 32'hdeadbeef, 4'hf, "R5 cop blocked write");
    cpu_op(0, 5, 0, 0, "R5 data intact");
    cpu_op(1, 5, 32'haabbccdd, 4'b0101, "R9 partial write");
    cpu_op(0, 5, 0, 0, "R9 merged bytes");
    cpu_op(2, 5, 0, 0, "R2 cpu fetch");
    cpu_op(3, 5, 0, 0, "R2 cpu debug read");
    cpu_op(6, 5, 0, 0, "R5 undefined kind");

    set_cfg(0, 1, 0, 0);
    cop_op(2, 5, 0, 0, "R2 prog flag ignored");
    cpu_op(0, 5, 0, 0, "R2 cpu full");
    set_cfg(2, 0, 0, 0);
    cop_op(0, 5, 0, 0, "R2 reserved code 10");
    set_cfg(3, 1, 0, 0);
    cop_op(2, 5, 0, 0, "R2 reserved code 11");

    set_cfg(1, 0, 0, 0);
    cop_op(1, 6, 32'h01020304, 4'hf, "R11 shared at once");
    cop_op(0, 6, 0, 0, "R3 cop data read");
    cop_op(2, 6, 0, 0, "R3 cop fetch refused");
    cop_op(3, 6, 0, 0, "R3 cop debug refused");
    cpu_op(0, 6, 0, 0, "R3 cpu read");
    cpu_op(1, 7, 32'h77777777, 4'hf, "R3 cpu write");
    step(1, 0, 6, 0, 0, 1, 1, 6, 32'hffffffff, 4'hf, 0, "R8 collision");
    cop_op(0, 6, 0, 0, "R8 dropped write");

    set_cfg(1, 1, 0, 0);
    cop_op(2, 6, 0, 0, "R4 cop fetch");
    cop_op(0, 6, 0, 0, "R4 cop read refused");
    cpu_op(0, 6, 0, 0, "R4 cpu read refused");
    cpu_op(1, 6, 32'h12345678, 4'hf, "R4 cpu write refused");
    cpu_op(3, 6, 0, 0, "R4 debug read intact");
    cpu_op(4, 6, 32'hcafef00d, 4'hf, "R4 debug write");
    cpu_op(3, 6, 0, 0, "R4 debug read back");
    cpu_op(2, 6, 0, 0, "R4 cpu fetch refused");

    set_cfg(1, 0, 1, 1);
    cpu_op(1, 7, 32'h0badf00d, 4'hf, "R6 write protect");
    cpu_op(0, 7, 0, 0, "R6 data intact");
    cpu_op(4, 7, 32'h5a5a5a5a, 4'hf, "R6 debug write allowed");
    cpu_op(2, 7, 0, 0, "R6 fetch protect");
    cop_op(1, 7, 32'h0000abcd, 4'h3, "R6 cop unaffected");
    cpu_op(0, 7, 0, 0, "R6 read back");

    set_cfg(0, 0, 0, 0);
    step(1, 1, 9, 32'h55aa55aa, 4'hf, 0, 0, 0, 0, 0, 1, "R10 inject");
    cpu_op(0, 9, 0, 0, "R10 parity error");
    cpu_op(1, 9, 32'h000000ee, 4'b0001, "R10 partial clean");
    cpu_op(0, 9, 0, 0, "R10 still bad");
    cpu_op(1, 9, 32'h01010101, 4'hf, "R10 full clean");
    cpu_op(0, 9, 0, 0, "R10 clean read");
    cpu_op(1, 9, 0, 4'hf, "R10 write no check");

    repeat (3) step(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, "idle");
    @(negedge clk);
    @(negedge clk);
    summary();
    $finish;
  end

endmodule